// File: doc/BRIEF.md
# Overload Hiccup Sequencer

This block decides, for one output channel of a supply regulator, whether the power stage may conduct and whether an overload is reported. It watches the level of an overcurrent comparator and reacts in one of two ways. In static mode the stage stays on, an external clamp limits the current, and the overload flag simply mirrors the comparator. In dynamic (hiccup) mode a detected overload shuts the stage off for a long rest period and then lets it run for a short retry window. The flag is held high for the whole episode. The channel only returns to normal running once a complete retry window passes with no overload seen.

All timing is counted in ticks of a slow timebase. The timebase is made by dividing a converter clock tick input by `PRESC`. The rest period is `T_OFF` timebase ticks and the retry window is `T_ON` ticks. At a 220 kHz converter tick, `PRESC` = 22 gives a 0.1 ms timebase, so a 900 ms rest is 9000 ticks and a 20 ms window is 200 ticks. A simulation can use much shorter values. Clearing the channel enable or raising over-temperature shutdown sends the sequencer back to idle at once.

States: IDLE (stage off, flag low), SOFT (soft-start in progress, stage on, flag low), RUN (normal running), OFF (hiccup rest, stage off, flag high) and ON (retry window, stage on, flag high).

Transitions:
- kill, from any state to IDLE, when the enable is low or shutdown is high.
- start, IDLE to SOFT.
- settle, SOFT to RUN.
- trip, RUN to OFF.
- retry, OFF to ON.
- refault, ON to OFF.
- recover, ON to RUN.
- go_static, OFF or ON to RUN.

Top module: `lnb_ovl_seq`

## Requirements
- R1: During and right after reset, with the enable low, `stage_en` and `ovl_flag` are both 0.
- R2: With the enable high and no shutdown, `stage_en` is 1 from the cycle after the enable is seen. `ovl_flag` stays 0 and the comparator is ignored until `ss_done` is seen high.
- R3: In normal running with `static_mode` = 0, a comparator level of 1 sampled at a clock edge gives `stage_en` = 0 and `ovl_flag` = 1 after that edge.
- R4: The rest period lasts exactly `T_OFF`·`PRESC` converter ticks, counted from the trip edge. The timebase restarts at the trip.
- R5: After the rest period, `stage_en` returns to 1 for the retry window while `ovl_flag` stays 1.
- R6: During the retry window the comparator is examined only on timebase ticks. A 1 seen on any such tick, even a one-cycle pulse, starts a new full rest period. A 1 seen between ticks has no effect.
- R7: When all `T_ON` ticks of the window pass with the comparator at 0, the channel returns to normal running and `ovl_flag` drops to 0 on that last tick.
- R8: In normal running with `static_mode` = 1, `stage_en` stays 1. `ovl_flag` equals the comparator level of the previous clock edge.
- R9: Raising `static_mode` during a rest or retry period returns the channel to normal running at the next edge.
- R10: `ot_shdn` = 1 gives `stage_en` = 0 and `ovl_flag` = 0 after the next edge, from any state, and clears the timers. Once it is released the channel restarts through soft-start.
- R11: `ch_en` = 0 has the same effect as R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cvt_tick | input | 1 | One-cycle pulse per converter clock period |
| ch_en | input | 1 | Channel enable |
| static_mode | input | 1 | 1 = static clamp, 0 = dynamic hiccup |
| oc_level | input | 1 | Overcurrent comparator level |
| ss_done | input | 1 | Soft-start finished |
| ot_shdn | input | 1 | Over-temperature shutdown |
| stage_en | output | 1 | Power stage enable |
| ovl_flag | output | 1 | Overload flag |

## Verification
A wrong state shows on the two outputs within one clock, because both are decoded from the state register or from a flag written alongside it. Rest and retry states differ only in `stage_en`, so a wrong timer or prescaler count shows up as a rest period or window edge that is early or late by a whole number of converter ticks. The bench therefore drives the converter tick on every cycle for directed runs, where every edge falls on a known cycle. It randomizes the tick and the comparator in a long stress run that is compared against a behavioural model on every clock.

// File: rtl/ovlh_pkg.sv
package ovlh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SOFT = 3'd1,
        ST_RUN  = 3'd2,
        ST_OFF  = 3'd3,
        ST_ON   = 3'd4
    } ovlh_state_e;

    function automatic logic in_fault(input ovlh_state_e s);
        return (s == ST_OFF) || (s == ST_ON);
    endfunction

endpackage

// File: rtl/ovlh_prescale.sv
module ovlh_prescale #(
    parameter int PRESC = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cvt_tick,
    input  logic clr,
    output logic slow_tick
);

    generate
        if (PRESC <= 1) begin : g_pass
            assign slow_tick = cvt_tick && !clr;
        end else begin : g_div
            localparam int PW = $clog2(PRESC);
            localparam logic [PW-1:0] LAST = PW'(PRESC - 1);

            logic [PW-1:0] pcnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pcnt_q <= '0;
                end else if (clr) begin
                    pcnt_q <= '0;
                end else if (cvt_tick) begin
                    pcnt_q <= (pcnt_q == LAST) ? '0 : pcnt_q + 1'b1;
                end
            end

            assign slow_tick = cvt_tick && !clr && (pcnt_q == LAST);

            // R4
            pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pcnt_q <= LAST);

            // R4
            pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr && !cvt_tick) |=> $stable(pcnt_q));
        end
    endgenerate

endmodule

// File: rtl/ovlh_timer.sv
module ovlh_timer #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == CW'(1));

    // R4
    tmr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !clr && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5
    tmr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/ovlh_fsm.sv
module ovlh_fsm
    import ovlh_pkg::*;
#(
    parameter int T_OFF = 9000,
    parameter int T_ON  = 200,
    parameter int CW    = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ch_en,
    input  logic          static_mode,
    input  logic          oc_level,
    input  logic          ss_done,
    input  logic          ot_shdn,
    input  logic          slow_tick,
    input  logic          tmr_last,
    output logic          pre_clr,
    output logic          tmr_clr,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          stage_en,
    output logic          ovl_flag
);

    ovlh_state_e state_q, state_d;
    logic        flag_q, flag_d;
    logic        kill;

    assign kill = !ch_en || ot_shdn;

    // next state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = CW'(T_OFF);
        if (kill) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_SOFT;
                ST_SOFT: if (ss_done) state_d = ST_RUN;
                ST_RUN: begin
                    if (!static_mode && oc_level) begin
                        state_d  = ST_OFF;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(T_OFF);
                    end
                end
                ST_OFF: begin
                    if (static_mode) begin
                        state_d = ST_RUN;
                    end else if (slow_tick && tmr_last) begin
                        state_d  = ST_ON;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(T_ON);
                    end
                end
                ST_ON: begin
                    if (static_mode) begin
                        state_d = ST_RUN;
                    end else if (slow_tick) begin
                        if (oc_level) begin
                            state_d  = ST_OFF;
                            tmr_load = 1'b1;
                            tmr_val  = CW'(T_OFF);
                        end else if (tmr_last) begin
                            state_d = ST_RUN;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        if (in_fault(state_d)) begin
            flag_d = 1'b1;
        end else if (state_d == ST_RUN && static_mode) begin
            flag_d = oc_level;
        end else begin
            flag_d = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            flag_q  <= flag_d;
        end
    end

    // outputs
    always_comb begin
        stage_en = (state_q == ST_SOFT) || (state_q == ST_RUN) || (state_q == ST_ON);
        ovl_flag = flag_q;
        pre_clr  = !in_fault(state_q);
        tmr_clr  = !in_fault(state_q);
    end

    // R3
    dyn_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !static_mode && oc_level && !kill) |=> (!stage_en && ovl_flag));

    // R2
    soft_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SOFT) |-> !ovl_flag);

    // R7
    recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_ON && state_q == ST_RUN) |-> ($past(slow_tick) || $past(static_mode)));

    // R8
    static_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && static_mode && !kill) |=> (stage_en && ovl_flag == $past(oc_level)));

    // R10
    ot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ot_shdn |=> (!stage_en && !ovl_flag));

    // R11
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> (!stage_en && !ovl_flag));

    // R5
    fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_fault(state_q) |-> ovl_flag);

endmodule

// File: rtl/lnb_ovl_seq.sv
module lnb_ovl_seq #(
    parameter int PRESC = 22,
    parameter int T_OFF = 9000,
    parameter int T_ON  = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cvt_tick,
    input  logic ch_en,
    input  logic static_mode,
    input  logic oc_level,
    input  logic ss_done,
    input  logic ot_shdn,
    output logic stage_en,
    output logic ovl_flag
);

    localparam int TMAX = (T_OFF > T_ON) ? T_OFF : T_ON;
    localparam int CW   = $clog2(TMAX + 1);

    logic          slow_tick;
    logic          pre_clr;
    logic          tmr_clr;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_last;

    ovlh_prescale #(.PRESC(PRESC)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .cvt_tick  (cvt_tick),
        .clr       (pre_clr),
        .slow_tick (slow_tick)
    );

    ovlh_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (tmr_clr),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (slow_tick),
        .last     (tmr_last)
    );

    ovlh_fsm #(.T_OFF(T_OFF), .T_ON(T_ON), .CW(CW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ch_en       (ch_en),
        .static_mode (static_mode),
        .oc_level    (oc_level),
        .ss_done     (ss_done),
        .ot_shdn     (ot_shdn),
        .slow_tick   (slow_tick),
        .tmr_last    (tmr_last),
        .pre_clr     (pre_clr),
        .tmr_clr     (tmr_clr),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .stage_en    (stage_en),
        .ovl_flag    (ovl_flag)
    );

    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !ch_en) |-> (!stage_en && !ovl_flag));

endmodule

// File: tb/test_lnb_ovl_seq.sv
module test_lnb_ovl_seq;

    localparam int PRESC = 3;
    localparam int T_OFF = 4;
    localparam int T_ON  = 3;

    logic clk = 1'b0;
    logic rst_n, cvt_tick, ch_en, static_mode, oc_level, ss_done, ot_shdn;
    logic stage_en, ovl_flag;

    always #2.5 clk = ~clk;

    lnb_ovl_seq #(.PRESC(PRESC), .T_OFF(T_OFF), .T_ON(T_ON)) i_lnb_ovl_seq (
        .clk(clk), .rst_n(rst_n), .cvt_tick(cvt_tick), .ch_en(ch_en),
        .static_mode(static_mode), .oc_level(oc_level), .ss_done(ss_done),
        .ot_shdn(ot_shdn), .stage_en(stage_en), .ovl_flag(ovl_flag)
    );

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string phase = "R1";
    bit    tick_every = 1;

    // behavioural reference: 0 idle, 1 soft, 2 run, 3 rest, 4 retry
    int m_st = 0, m_pc = 0, m_left = 0;
    bit m_flag = 0, m_tk = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_flag = 0; m_pc = 0; m_left = 0;
        end else begin
            m_tk = 0;
            if (m_st == 3 || m_st == 4) begin
                if (cvt_tick) begin
                    if (m_pc == PRESC - 1) begin m_tk = 1; m_pc = 0; end
                    else m_pc = m_pc + 1;
                end
            end else begin
                m_pc = 0;
            end
            if (!ch_en || ot_shdn) begin
                m_st = 0;
            end else begin
                case (m_st)
                    0: m_st = 1;
                    1: if (ss_done) m_st = 2;
                    2: if (!static_mode && oc_level) begin m_st = 3; m_left = T_OFF; end
                    3: begin
                        if (static_mode) m_st = 2;
                        else if (m_tk) begin
                            if (m_left == 1) begin m_st = 4; m_left = T_ON; end
                            else m_left = m_left - 1;
                        end
                    end
                    default: begin
                        if (static_mode) m_st = 2;
                        else if (m_tk) begin
                            if (oc_level) begin m_st = 3; m_left = T_OFF; end
                            else if (m_left == 1) m_st = 2;
                            else m_left = m_left - 1;
                        end
                    end
                endcase
            end
            m_flag = (m_st == 3 || m_st == 4) ? 1'b1 : ((m_st == 2 && static_mode) ? oc_level : 1'b0);
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            bit m_en;
            m_en = (m_st == 1 || m_st == 2 || m_st == 4);
            total++;
            if (stage_en !== m_en || ovl_flag !== m_flag) begin
                bad++;
                $display("FAIL %s model: stage_en=%b flag=%b expected stage_en=%b flag=%b",
                         phase, stage_en, ovl_flag, m_en, m_flag);
            end
        end
    end

    always @(negedge clk) begin
        cvt_tick <= tick_every ? 1'b1 : 1'($urandom_range(0, 1));
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 0; ch_en = 0; static_mode = 0; oc_level = 0; ss_done = 0; ot_shdn = 0;
        cyc(3);
        chk("R1", "stage_en in reset", stage_en, 1'b0);
        chk("R1", "flag in reset", ovl_flag, 1'b0);
        rst_n = 1;
        cyc(2);
        chk("R1", "stage_en after reset", stage_en, 1'b0);

        // R2 soft-start ignores the comparator
        phase = "R2";
        ch_en = 1; oc_level = 1;
        cyc(5);
        chk("R2", "stage_en soft", stage_en, 1'b1);
        chk("R2", "flag soft", ovl_flag, 1'b0);
        oc_level = 0; ss_done = 1;
        cyc(2);

        // R3 trip, R4 rest length, R5 retry, R7 recovery (tick every cycle)
        phase = "R3";
        oc_level = 1; cyc(1); oc_level = 0;
        chk("R3", "stage_en trip", stage_en, 1'b0);
        chk("R3", "flag trip", ovl_flag, 1'b1);
        phase = "R4";
        cyc(11);
        chk("R4", "stage_en last rest cycle", stage_en, 1'b0);
        phase = "R5";
        cyc(1);
        chk("R5", "stage_en retry", stage_en, 1'b1);
        chk("R5", "flag retry", ovl_flag, 1'b1);
        phase = "R7";
        cyc(8);
        chk("R7", "flag before last tick", ovl_flag, 1'b1);
        cyc(1);
        chk("R7", "flag recovered", ovl_flag, 1'b0);
        chk("R7", "stage_en recovered", stage_en, 1'b1);

        // R6 pulse between ticks is ignored, pulse on a tick restarts the rest
        phase = "R6";
        oc_level = 1; cyc(1); oc_level = 0;
        cyc(12);
        chk("R6", "in retry window", stage_en, 1'b1);
        oc_level = 1; cyc(1); oc_level = 0;
        chk("R6", "pulse off tick ignored", stage_en, 1'b1);
        cyc(1);
        oc_level = 1; cyc(1); oc_level = 0;
        chk("R6", "pulse on tick restarts rest", stage_en, 1'b0);
        chk("R6", "flag kept", ovl_flag, 1'b1);
        cyc(11);
        chk("R6", "full new rest", stage_en, 1'b0);
        cyc(1);
        chk("R6", "retry after new rest", stage_en, 1'b1);
        cyc(12);

        // R6 randomized stress against the model
        tick_every = 0;
        for (int i = 0; i < 1500; i++) begin
            oc_level = ($urandom_range(0, 9) < 2);
            cyc(1);
        end
        oc_level = 0;
        cyc(80);
        tick_every = 1;

        // R8 static mode
        phase = "R8";
        static_mode = 1;
        cyc(2);
        oc_level = 1; cyc(1);
        chk("R8", "flag follows high", ovl_flag, 1'b1);
        chk("R8", "stage_en static", stage_en, 1'b1);
        cyc(5);
        chk("R8", "stage_en held", stage_en, 1'b1);
        oc_level = 0; cyc(1);
        chk("R8", "flag follows low", ovl_flag, 1'b0);

        // R9 switch to static during a fault
        phase = "R9";
        static_mode = 0;
        oc_level = 1; cyc(1); oc_level = 0;
        cyc(3);
        static_mode = 1; cyc(1);
        chk("R9", "stage_en after static", stage_en, 1'b1);
        chk("R9", "flag after static", ovl_flag, 1'b0);
        static_mode = 0;
        cyc(2);

        // R10 over-temperature
        phase = "R10";
        oc_level = 1; cyc(1); oc_level = 0;
        cyc(2);
        ot_shdn = 1; cyc(1);
        chk("R10", "stage_en shutdown", stage_en, 1'b0);
        chk("R10", "flag shutdown", ovl_flag, 1'b0);
        cyc(3);
        ot_shdn = 0; cyc(1);
        chk("R10", "restart soft", stage_en, 1'b1);
        chk("R10", "restart flag", ovl_flag, 1'b0);
        cyc(3);

        // R11 channel enable
        phase = "R11";
        oc_level = 1; cyc(1); oc_level = 0;
        cyc(13);
        ch_en = 0; cyc(1);
        chk("R11", "stage_en disabled", stage_en, 1'b0);
        chk("R11", "flag disabled", ovl_flag, 1'b0);
        ch_en = 1; cyc(3);
        chk("R11", "running again", stage_en, 1'b1);

        finish_run();
    end

endmodule